// File: doc/BRIEF.md
# Two-Level Chained DMA Request Arbiter

This block decides which of eight DMA request lines owns the system bus. The lines come in two groups of four. The upper group talks to the CPU through a hold request and hold acknowledge pair. The lower group does not see the CPU at all. Its own hold request is fed in as the request of upper-group slot 0, and the acknowledge of that slot comes back as the lower group's hold acknowledge. Upper slot 0 is therefore always chained and has no device port. System channels 0–3 are the lower group, channel 4 is the chaining slot, and channels 5–7 are upper slots 1–3.

Each group has a fixed priority: the lowest slot number wins. A channel can be set to pass-through (bus-master) mode. In that mode a grant raises only the channel's acknowledge, and it holds until the device drops its request. The address-drive flag stays low, because the device drives the bus itself. A normal channel receives a one-cycle acknowledge per grant, and the flags show that the controller drives the address: a byte slot in the lower group or a word slot in the upper group. Address counting and data movement belong to other blocks.

Top module: `dma_casc_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_hrq`, every `dack` bit, `addr_en` and `word_sel` are 0.
- R2: When several unmasked requests in one group are pending at an arbitration point, the lowest-numbered one is granted first (channel 1 before 3, channel 6 before 7).
- R3: A channel whose `chan_mask` bit is 1 is never acknowledged and its request alone raises no `cpu_hrq`; clearing the mask lets the pending request be served.
- R4: Any lower-group channel (0–3) requesting at an upper-group arbitration point is served before channels 5–7, because it enters through upper slot 0.
- R5: `dack[4]` is always 0. `dreq[4]`, `chan_mask[4]` and `chan_casc[4]` have no effect, so a request on bit 4 alone raises no `cpu_hrq`.
- R6: A granted channel whose `chan_casc` bit is 1 keeps its acknowledge with `addr_en` 0 for as long as its request stays high, and is not preempted by a higher-priority request.
- R7: A granted channel whose `chan_casc` bit is 0 receives a one-cycle acknowledge with `addr_en` 1. `word_sel` is 1 for channels 5–7 and 0 for channels 0–3.
- R8: At most one `dack` bit is 1 in any cycle.
- R9: When a grant ends and another request is pending, the next channel is granted without `cpu_hrq` dropping in between.
- R10: When no request is pending after a grant, `cpu_hrq` falls. It stays low until `cpu_hlda` has returned to 0.
- R11: No acknowledge is given unless `cpu_hlda` is 1. A request first raises `cpu_hrq`, and the grant follows the CPU's acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 8 | Device requests by system channel (bit 4 unused) |
| chan_mask | input | 8 | 1 = channel masked (bit 4 unused) |
| chan_casc | input | 8 | 1 = pass-through bus-master mode (bit 4 unused) |
| cpu_hlda | input | 1 | CPU hold acknowledge |
| cpu_hrq | output | 1 | Hold request to the CPU |
| dack | output | 8 | Device acknowledges by system channel (bit 4 always 0) |
| addr_en | output | 1 | Controller drives address and strobes for the granted channel |
| word_sel | output | 1 | The driving channel is an upper-group (16-bit) slot |

## Verification
The assertions check several rules on every cycle:
- Acknowledges are one-hot.
- An acknowledge is given only under a hold acknowledge.
- Each new grant picks the lowest unmasked request in its group.
- A pass-through acknowledge stays stable while its request is high.
- A released hold request stays low until the acknowledge falls.
- The word flag is tied to an upper-group driving grant.

Other behaviour shows only in the bench's scenarios:
- The grant order across the two groups.
- The hand-off without dropping the hold request.
- A masked request resuming once unmasked.
- Channel 4 having no effect.
- The release sequence under a slow CPU.

// File: rtl/dma_casc_pkg.sv
package dma_casc_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE    = 2'd0,
    ARB_HOLD    = 2'd1,
    ARB_GRANT   = 2'd2,
    ARB_RELEASE = 2'd3
  } arb_state_e;

  // Bits strictly below position n set; used to express "no higher-priority slot".
  function automatic logic [7:0] below_mask(input int unsigned n);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Slot index to one-hot.
  function automatic logic [7:0] slot_onehot(input int unsigned n);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i == int'(n)) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  output logic           any,
  output logic [IW-1:0]  idx
);

  // Fixed priority: lowest slot number wins.
  always_comb begin
    any = |elig;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dma_grp_arb.sv
module dma_grp_arb
  import dma_casc_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mask,
  input  logic [NCH-1:0] casc,
  input  logic           hlda_in,
  output logic           hold_req,
  output logic [NCH-1:0] ack,
  output logic           drv
);

  arb_state_e    state;
  logic [IW-1:0] sel;
  logic          casc_lat;

  logic [NCH-1:0] elig;
  logic           any;
  logic [IW-1:0]  idx;

  // Named internal events for the checks below.
  logic cur_keep;
  logic grant_evt;
  logic release_evt;

  assign elig = req & ~mask;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .elig (elig),
    .any  (any),
    .idx  (idx)
  );

  assign cur_keep    = (state == ARB_GRANT) && casc_lat && req[sel];
  assign grant_evt   = ((state == ARB_HOLD) && hlda_in && any) ||
                       ((state == ARB_GRANT) && !cur_keep && any);
  assign release_evt = ((state == ARB_HOLD) && hlda_in && !any) ||
                       ((state == ARB_GRANT) && !cur_keep && !any);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ARB_IDLE;
      sel      <= '0;
      casc_lat <= 1'b0;
    end else begin
      if (grant_evt) begin
        sel      <= idx;
        casc_lat <= casc[idx];
      end
      unique case (state)
        ARB_IDLE:    if (any && !hlda_in) state <= ARB_HOLD;
        ARB_HOLD:    if (grant_evt) state <= ARB_GRANT;
                     else if (release_evt) state <= ARB_RELEASE;
        ARB_GRANT:   if (release_evt) state <= ARB_RELEASE;
        ARB_RELEASE: if (!hlda_in) state <= ARB_IDLE;
        default:     state <= ARB_IDLE;
      endcase
    end
  end

  assign hold_req = (state == ARB_HOLD) || (state == ARB_GRANT);
  assign ack      = (state == ARB_GRANT) ? slot_onehot(32'(sel))[NCH-1:0] : '0;
  assign drv      = (state == ARB_GRANT) && !casc_lat;

  // R8: one acknowledge at most within the group
  a_r8_grp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));

  // R2: a new grant takes the lowest eligible slot
  a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |-> (elig[idx] && ((elig & below_mask(32'(idx))[NCH-1:0]) == '0)));

  // R3: a masked slot never starts a grant
  a_r3_masked_never_picked: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |-> !mask[idx]);

  // R6: a pass-through acknowledge holds while its request stays up
  a_r6_passthru_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cur_keep |=> (ack == $past(ack)));

  // R11: acknowledges only under hold acknowledge
  a_r11_ack_needs_hlda: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |-> hlda_in);

  // R10: after release, no new hold request until acknowledge falls
  a_r10_wait_hlda_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_req && hlda_in) |=> !hold_req);

endmodule

// File: rtl/dma_casc_arb.sv
module dma_casc_arb #(
  parameter int GRP_CH = 4,
  localparam int SYS_CH = 2 * GRP_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SYS_CH-1:0] dreq,
  input  logic [SYS_CH-1:0] chan_mask,
  input  logic [SYS_CH-1:0] chan_casc,
  input  logic              cpu_hlda,
  output logic              cpu_hrq,
  output logic [SYS_CH-1:0] dack,
  output logic              addr_en,
  output logic              word_sel
);

  logic              sec_hreq;
  logic [GRP_CH-1:0] sec_ack;
  logic              sec_drv;
  logic [GRP_CH-1:0] pri_req, pri_mask, pri_casc;
  logic [GRP_CH-1:0] pri_ack;
  logic              pri_drv;
  logic              unused_ch_bits;

  // Upper slot 0 is the chaining slot: fed by the lower group's hold request,
  // never masked, always pass-through.
  assign pri_req  = {dreq[SYS_CH-1:GRP_CH+1],      sec_hreq};
  assign pri_mask = {chan_mask[SYS_CH-1:GRP_CH+1], 1'b0};
  assign pri_casc = {chan_casc[SYS_CH-1:GRP_CH+1], 1'b1};
  assign unused_ch_bits = ^{dreq[GRP_CH], chan_mask[GRP_CH], chan_casc[GRP_CH]};

  dma_grp_arb #(.NCH(GRP_CH)) u_lower (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (dreq[GRP_CH-1:0]),
    .mask     (chan_mask[GRP_CH-1:0]),
    .casc     (chan_casc[GRP_CH-1:0]),
    .hlda_in  (pri_ack[0]),
    .hold_req (sec_hreq),
    .ack      (sec_ack),
    .drv      (sec_drv)
  );

  dma_grp_arb #(.NCH(GRP_CH)) u_upper (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (pri_req),
    .mask     (pri_mask),
    .casc     (pri_casc),
    .hlda_in  (cpu_hlda),
    .hold_req (cpu_hrq),
    .ack      (pri_ack),
    .drv      (pri_drv)
  );

  for (genvar g = 0; g < GRP_CH; g++) begin : g_ack_map
    assign dack[g] = sec_ack[g];
    if (g == 0) begin : g_chain
      assign dack[GRP_CH] = 1'b0;
    end else begin : g_dev
      assign dack[GRP_CH+g] = pri_ack[g];
    end
  end

  assign addr_en  = sec_drv | pri_drv;
  assign word_sel = pri_drv;

  // R8: system-wide single active channel
  a_r8_sys_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R7: word flag only for a driving upper-group grant
  a_r7_word_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
    word_sel |-> (addr_en && (dack[SYS_CH-1:GRP_CH] != '0)));

  // R6: address drive implies some device acknowledge is up
  a_r6_drive_has_ack: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en |-> (dack != '0));

endmodule

// File: tb/dma_casc_arb_tb.sv
module dma_casc_arb_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dreq = '0;
  logic [7:0] chan_mask = '0;
  logic [7:0] chan_casc = '0;
  logic       cpu_hlda = 1'b0;
  logic       cpu_hrq;
  logic [7:0] dack;
  logic       addr_en;
  logic       word_sel;

  dma_casc_arb #(.GRP_CH(4)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq      (dreq),
    .chan_mask (chan_mask),
    .chan_casc (chan_casc),
    .cpu_hlda  (cpu_hlda),
    .cpu_hrq   (cpu_hrq),
    .dack      (dack),
    .addr_en   (addr_en),
    .word_sel  (word_sel)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int pend[8];
  int clen[8];
  int ccnt[8];
  int lag = 1;
  logic [3:0] hist = '0;
  logic [7:0] prev_dack = '0;
  logic       prev_hrq = 1'b0;
  logic       rel = 1'b0;
  int         cycles = 0;
  bit         done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor, device model and CPU model, all at the falling edge.
  initial begin
    for (int c = 0; c < 8; c++) begin pend[c] = 0; clen[c] = 1; ccnt[c] = 0; end
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        chk(0, "watchdog", cycles, 100000);
        finish_run();
      end
      if (rst_n) begin
        // R8: single acknowledge
        if (dack != '0) chk($countones(dack) == 1, "R8", $countones(dack), 1);
        // R10: no hold request while the previous release is still acknowledged
        if (rel) begin
          if (cpu_hrq) chk(0, "R10", 1, 0);
          if (!cpu_hlda) begin rel = 0; chk(1, "R10", 0, 0); end
        end
        if (prev_hrq && !cpu_hrq) rel = 1;
        for (int c = 0; c < 8; c++) begin
          if (dack[c] && (!chan_casc[c] || !prev_dack[c])) begin
            if (exp_q.size() == 0) begin
              chk(0, "R2 unexpected grant", c, -1);
            end else begin
              int e;
              e = exp_q.pop_front();
              chk(c == e, "R2 grant order", c, e);
            end
            if (chan_casc[c]) chk(addr_en == 1'b0, "R6 addr_en", addr_en, 0);
            else              chk(addr_en == 1'b1, "R7 addr_en", addr_en, 1);
            chk(word_sel == (c >= 5 && !chan_casc[c]), "R7 word_sel",
                word_sel, (c >= 5 && !chan_casc[c]));
            chk(cpu_hlda == 1'b1, "R11 hlda at grant", cpu_hlda, 1);
          end
        end
      end
      prev_dack = dack;
      prev_hrq  = cpu_hrq;
      // device side
      for (int c = 0; c < 8; c++) begin
        if (dack[c]) begin
          if (chan_casc[c]) begin
            ccnt[c]++;
            if (ccnt[c] >= clen[c]) begin pend[c] = 0; ccnt[c] = 0; end
          end else if (pend[c] > 0) begin
            pend[c]--;
          end
        end
        dreq[c] = (pend[c] > 0);
      end
      // CPU side: hold acknowledge follows hold request after lag cycles
      hist = {hist[2:0], cpu_hrq};
      cpu_hlda = hist[lag-1];
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic post(input int ch, input int n, input int exp_ch);
    pend[ch] = n;
    if (exp_ch >= 0) exp_q.push_back(exp_ch);
  endtask

  task automatic drain(input string rq);
    int w;
    w = 0;
    while ((exp_q.size() != 0 || cpu_hrq || cpu_hlda) && w < 300) begin
      tick(1);
      w++;
    end
    tick(3);
    chk(exp_q.size() == 0, rq, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic idle_watch(input int n, input string rq);
    bit bad;
    bad = 0;
    repeat (n) begin
      @(negedge clk);
      #1;
      if (cpu_hrq || dack != '0) bad = 1;
    end
    chk(!bad, rq, bad, 0);
    tick(1);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(cpu_hrq == 0 && dack == 0 && addr_en == 0 && word_sel == 0, "R1 in reset",
        {cpu_hrq, dack, addr_en, word_sel}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(cpu_hrq == 0 && dack == 0 && addr_en == 0 && word_sel == 0, "R1 after reset",
        {cpu_hrq, dack, addr_en, word_sel}, 0);
    tick(1);

    // R11: single lower-group byte grant follows hold handshake
    post(2, 1, 2);
    drain("R11 single byte grant");

    // R2/R4/R9: two lower and two upper requests together
    post(1, 1, 1); post(3, 1, 3); post(6, 1, 6); post(7, 1, 7);
    drain("R9 back-to-back hand-off");

    // R3: masked channel stays silent, then served once unmasked
    chan_mask[0] = 1'b1;
    post(0, 1, -1);
    post(7, 1, 7);
    drain("R3 masked skipped");
    idle_watch(20, "R3 masked no hold");
    chan_mask[0] = 1'b0;
    exp_q.push_back(0);
    drain("R3 unmasked served");

    // R6/R4: upper pass-through not preempted by a lower request
    chan_casc[5] = 1'b1;
    clen[5] = 6;
    post(5, 1, 5);
    while (dack[5] !== 1'b1) tick(1);
    post(2, 1, 2);
    drain("R6 upper pass-through then R4 lower");
    chan_casc[5] = 1'b0;

    // R6: lower pass-through then upper word channel
    chan_casc[3] = 1'b1;
    clen[3] = 5;
    post(3, 1, 3); post(6, 1, 6);
    drain("R6 lower pass-through");
    chan_casc[3] = 1'b0;

    // R5: channel 4 request has no effect
    chan_casc[4] = 1'b1;
    post(4, 1, -1);
    idle_watch(20, "R5 channel 4 ignored");
    pend[4] = 0;
    chan_casc[4] = 1'b0;
    tick(2);

    // R10: slow CPU, new request arrives during release
    lag = 4;
    post(6, 1, 6);
    while (!cpu_hrq) tick(1);
    while (cpu_hrq) tick(1);
    post(1, 1, 1);
    drain("R10 release then new grant");
    lag = 1;

    // R7: repeated word transfers on one upper channel
    post(5, 3, 5);
    exp_q.push_back(5); exp_q.push_back(5);
    drain("R7 repeated word grants");

    done = 1;
    finish_run();
  end

endmodule